// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block tracks the coherence state of one cache line in a write-back cache that sits on a snooping bus and uses invalidation. It keeps four stable states: Invalid, Shared, Exclusive (sole copy, clean) and Modified (sole copy, dirty). Processor reads and writes arrive on a request port that is held until `cpu_done`. Misses and upgrades become bus requests. Transactions from other caches arrive on a snoop port. The block answers them on a wired-OR shared line and on a data-supply strobe.

A read miss issues a plain read. In the cycle after the grant, the controller samples the wired-OR shared line. It fills the line as Exclusive when no other cache answered and as Shared when one did. A later write to an Exclusive line completes locally with no bus traffic. The static parameter `CLEAN_SUPPLY` chooses who supplies data for a snoop that hits a clean copy. When it is set, a clean holder supplies the data only while its priority input is high. When it is clear, memory always supplies clean data. A dirty line always supplies its data.

The controller uses these named states. Stable states: `ST_I`, `ST_S`, `ST_E`, `ST_M`. Transient states: `ST_IS_REQ` (read miss waiting for grant), `ST_IS_SNP` (shared-line sampling cycle), `ST_IM_REQ` (write without copy waiting for grant) and `ST_SM_REQ` (upgrade from Shared waiting for grant).

The transitions are:
- read miss: I→IS_REQ→IS_SNP→E or S
- write without copy: I→IM_REQ→M
- upgrade: S→SM_REQ→M
- silent write: E→M
- snooped read: E or M→S, with M flushing its data
- snooped read-for-ownership: S, E or M→I
- lost copy during upgrade: SM_REQ→IM_REQ

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset `line_state` is 0 and `bus_req`, `cpu_done`, `shr_out` and `sup_out` are low. The `line_state` encoding is I=0, S=1, E=2, M=3. States waiting for a fill report I, and an upgrade waiting for its grant reports S.
- R2: A read in state I raises `bus_req` with `bus_cmd`=0 (read) from the next cycle and holds it until `bus_gnt`. In the cycle after the grant, `cpu_done` is high and `shr_in` is sampled. The line then becomes E if `shr_in` was low and S if it was high.
- R3: A snoop hit (`snp_vld` and `snp_match`) with `snp_cmd`=0 (read) on a line holding a copy (S, E, M or upgrade pending) drives `shr_out` high in the next cycle. A read-for-ownership snoop does not drive it.
- R4: A write to an Exclusive line completes in the same cycle (`cpu_done`) with no `bus_req` and moves the line to M.
- R5: A write in S or I raises `bus_req` with `bus_cmd`=1 (read-for-ownership) until `bus_gnt`. `cpu_done` is high in the grant cycle and the line is M afterwards.
- R6: A snooped read moves M to S and E to S. On M, `sup_out` is high in the next cycle.
- R7: A snooped read-for-ownership (`snp_cmd`=1) moves S, E or M to I, and M asserts `sup_out` in the next cycle. During a pending upgrade it drops the copy: the line reports I and the write still completes to M at the grant.
- R8: With `CLEAN_SUPPLY`=1, a snoop hit on a clean copy (S or E) asserts `sup_out` only when `snp_pri` is high. With `CLEAN_SUPPLY`=0, clean copies never assert it.
- R9: A read in S, E or M completes in the same cycle with no bus request and no state change.
- R10: When a snoop hit and a processor request fall in the same cycle, the snoop is applied first and `cpu_done` stays low. The request is then served from the updated state.
- R11: A snoop with `snp_vld` low or `snp_match` low leaves `line_state`, `shr_out` and `sup_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Processor read request, held until done |
| cpu_wr | input | 1 | Processor write request, held until done (wins over read) |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 1 | 0 read, 1 read-for-ownership |
| bus_gnt | input | 1 | Grant; the request's address phase is this cycle |
| snp_vld | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 1 | Snooped command, 0 read, 1 read-for-ownership |
| snp_match | input | 1 | Snooped address matches this line |
| snp_pri | input | 1 | This cache is the chosen clean supplier |
| shr_in | input | 1 | Wired-OR shared line as seen on the bus |
| shr_out | output | 1 | This cache's contribution to the shared line |
| sup_out | output | 1 | This cache drives the line's data this cycle |
| line_state | output | 2 | Visible coherence state |

## Verification
Two things can fall in the same cycle: a snoop hit and a processor request against the same line. The bench provokes this by raising a snoop and a request on the same clock. Cases include a write on Exclusive against a read-for-ownership, a read on Modified against a read, and a read-for-ownership arriving while an upgrade waits for its grant. The bench checks that `cpu_done` stays low in the snoop cycle and that the snoop response reflects the old state. It then checks that the request is served from the post-snoop state, for example a write that had been silent now issues a read-for-ownership. Random sequences mix both kinds of traffic and compare against a bench state model.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [2:0] {
        ST_I      = 3'd0,
        ST_S      = 3'd1,
        ST_E      = 3'd2,
        ST_M      = 3'd3,
        ST_IS_REQ = 3'd4,
        ST_IS_SNP = 3'd5,
        ST_IM_REQ = 3'd6,
        ST_SM_REQ = 3'd7
    } ctl_state_e;

    localparam logic CMD_RD  = 1'b0;
    localparam logic CMD_RDX = 1'b1;

    localparam logic [1:0] VIS_I = 2'd0;
    localparam logic [1:0] VIS_S = 2'd1;
    localparam logic [1:0] VIS_E = 2'd2;
    localparam logic [1:0] VIS_M = 2'd3;
endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter bit CLEAN_SUPPLY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic snp_hit,
    input  logic snp_cmd,
    input  logic holds_copy,
    input  logic is_dirty,
    input  logic snp_pri,
    output logic shr_out,
    output logic sup_out
);
    logic shr_d;
    logic sup_d;

    always_comb begin
        shr_d = snp_hit && holds_copy && (snp_cmd == CMD_RD);
        sup_d = snp_hit && (is_dirty || (CLEAN_SUPPLY && holds_copy && snp_pri));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shr_out <= 1'b0;
            sup_out <= 1'b0;
        end else begin
            shr_out <= shr_d;
            sup_out <= sup_d;
        end
    end

    // R8: memory-only variant never lets a clean copy drive data
    a_r8_clean_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!CLEAN_SUPPLY && snp_hit && !is_dirty) |=> !sup_out);

    // R11: a miss on the snoop port produces no response
    a_r11_no_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_hit |=> (!shr_out && !sup_out));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter bit CLEAN_SUPPLY = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_rd,
    input  logic       cpu_wr,
    output logic       cpu_done,
    output logic       bus_req,
    output logic       bus_cmd,
    input  logic       bus_gnt,
    input  logic       snp_vld,
    input  logic       snp_cmd,
    input  logic       snp_match,
    input  logic       snp_pri,
    input  logic       shr_in,
    output logic       shr_out,
    output logic       sup_out,
    output logic [1:0] line_state
);
    ctl_state_e state_q;
    ctl_state_e state_d;
    logic       hit;
    logic       holds_copy;
    logic       is_dirty;

    assign hit        = snp_vld && snp_match;
    assign holds_copy = (state_q == ST_S) || (state_q == ST_E) ||
                        (state_q == ST_M) || (state_q == ST_SM_REQ);
    assign is_dirty   = (state_q == ST_M);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_I;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        cpu_done = 1'b0;
        unique case (state_q)
            ST_I: begin
                if (!hit) begin
                    if (cpu_wr)      state_d = ST_IM_REQ;
                    else if (cpu_rd) state_d = ST_IS_REQ;
                end
            end
            ST_S: begin
                if (hit) begin
                    if (snp_cmd == CMD_RDX) state_d = ST_I;
                end else if (cpu_wr) begin
                    state_d = ST_SM_REQ;
                end else if (cpu_rd) begin
                    cpu_done = 1'b1;
                end
            end
            ST_E: begin
                if (hit) begin
                    state_d = (snp_cmd == CMD_RDX) ? ST_I : ST_S;
                end else if (cpu_wr) begin
                    state_d  = ST_M;
                    cpu_done = 1'b1;
                end else if (cpu_rd) begin
                    cpu_done = 1'b1;
                end
            end
            ST_M: begin
                if (hit) begin
                    state_d = (snp_cmd == CMD_RDX) ? ST_I : ST_S;
                end else if (cpu_wr || cpu_rd) begin
                    cpu_done = 1'b1;
                end
            end
            ST_IS_REQ: begin
                if (bus_gnt) state_d = ST_IS_SNP;
            end
            ST_IS_SNP: begin
                cpu_done = 1'b1;
                state_d  = shr_in ? ST_S : ST_E;
            end
            ST_IM_REQ: begin
                if (bus_gnt) begin
                    cpu_done = 1'b1;
                    state_d  = ST_M;
                end
            end
            ST_SM_REQ: begin
                if (bus_gnt) begin
                    cpu_done = 1'b1;
                    state_d  = ST_M;
                end else if (hit && snp_cmd == CMD_RDX) begin
                    state_d = ST_IM_REQ;
                end
            end
            default: state_d = ST_I;
        endcase
    end

    always_comb begin
        bus_req = (state_q == ST_IS_REQ) || (state_q == ST_IM_REQ) ||
                  (state_q == ST_SM_REQ);
        bus_cmd = (state_q == ST_IS_REQ) ? CMD_RD : CMD_RDX;
        unique case (state_q)
            ST_S, ST_SM_REQ: line_state = VIS_S;
            ST_E:            line_state = VIS_E;
            ST_M:            line_state = VIS_M;
            default:         line_state = VIS_I;
        endcase
    end

    mesi_snoop_resp #(.CLEAN_SUPPLY(CLEAN_SUPPLY)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .snp_hit    (hit),
        .snp_cmd    (snp_cmd),
        .holds_copy (holds_copy),
        .is_dirty   (is_dirty),
        .snp_pri    (snp_pri),
        .shr_out    (shr_out),
        .sup_out    (sup_out)
    );

    // R3: a snooped read against a held copy raises the shared line next cycle
    a_r3_share_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && snp_cmd == CMD_RD && holds_copy) |=> shr_out);

    // R4: write on Exclusive is silent and lands in Modified
    a_r4_silent_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_E && cpu_wr && !hit) |=> (line_state == VIS_M && !bus_req));

    // R5: a bus request stays up with a steady command until granted
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd)));

    // R6: a dirty line flushes on any snoop hit
    a_r6_dirty_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_M && hit) |=> sup_out);

    // R7: read-for-ownership drops a stable valid copy
    a_r7_rdx_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && snp_cmd == CMD_RDX && state_q inside {ST_S, ST_E, ST_M})
        |=> (line_state == VIS_I));

    // R10: a snoop hit blocks completion of a processor request that cycle
    a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (cpu_rd || cpu_wr) && state_q inside {ST_I, ST_S, ST_E, ST_M})
        |-> !cpu_done);
endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_rd = 0, cpu_wr = 0, bus_gnt = 0;
    logic snp_vld = 0, snp_cmd = 0, snp_match = 0, snp_pri = 0, shr_in = 0;
    logic cpu_done, bus_req, bus_cmd, shr_out, sup_out;
    logic [1:0] line_state;
    logic cpu_done1, bus_req1, bus_cmd1, shr_out1, sup_out1;
    logic [1:0] line_state1;

    int n_chk = 0;
    int n_bad = 0;
    int mst = 0; // model state: 0 I, 1 S, 2 E, 3 M

    always #2 clk = ~clk;

    mesi_line_ctrl #(.CLEAN_SUPPLY(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(bus_cmd),
        .bus_gnt(bus_gnt), .snp_vld(snp_vld), .snp_cmd(snp_cmd),
        .snp_match(snp_match), .snp_pri(snp_pri), .shr_in(shr_in),
        .shr_out(shr_out), .sup_out(sup_out), .line_state(line_state));

    mesi_line_ctrl #(.CLEAN_SUPPLY(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_done(cpu_done1), .bus_req(bus_req1), .bus_cmd(bus_cmd1),
        .bus_gnt(bus_gnt), .snp_vld(snp_vld), .snp_cmd(snp_cmd),
        .snp_match(snp_match), .snp_pri(snp_pri), .shr_in(shr_in),
        .shr_out(shr_out1), .sup_out(sup_out1), .line_state(line_state1));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_shr(input int st, input int cmd, input int hit);
        return (hit != 0 && cmd == 0 && st != 0) ? 1 : 0;
    endfunction

    function automatic int exp_sup(input int st, input int hit, input int pri, input int clean);
        if (hit == 0) return 0;
        if (st == 3) return 1;
        return (clean != 0 && pri != 0 && (st == 1 || st == 2)) ? 1 : 0;
    endfunction

    function automatic int next_snp(input int st, input int cmd, input int hit);
        if (hit == 0 || st == 0) return st;
        if (cmd == 1) return 0;
        return (st == 3 || st == 2) ? 1 : st;
    endfunction

    // snoop cycle; optional processor request raised in the same cycle (R10)
    task automatic do_snoop(input int vld, input int cmd, input int match,
                            input int pri, input int rd, input int wr);
        int hit = vld & match;
        int e_shr = exp_shr(mst, cmd, hit);
        int e_sup0 = exp_sup(mst, hit, pri, 1);
        int e_sup1 = exp_sup(mst, hit, pri, 0);
        snp_vld = vld[0]; snp_cmd = cmd[0]; snp_match = match[0]; snp_pri = pri[0];
        cpu_rd = rd[0]; cpu_wr = wr[0];
        #1;
        if ((rd | wr) != 0 && hit != 0) chk("R10 done held during snoop", cpu_done, 0);
        @(negedge clk);
        snp_vld = 0; snp_match = 0; snp_pri = 0;
        mst = next_snp(mst, cmd, hit);
        if (hit == 0) begin
            chk("R11 shr quiet", shr_out, 0);
            chk("R11 sup quiet", sup_out, 0);
        end else begin
            chk("R3 shr_out", shr_out, e_shr);
            chk("R6 R7 R8 sup_out clean-supply", sup_out, e_sup0);
            chk("R8 sup_out memory-supply", sup_out1, e_sup1);
        end
        chk("R6 R7 R11 state after snoop", line_state, mst);
    endtask

    // processor access, starting at a negedge; request held until done
    task automatic do_cpu(input int wr, input int shr, input int gdly);
        int hitcase;
        cpu_wr = wr[0]; cpu_rd = ~wr[0];
        hitcase = (wr != 0) ? (mst >= 2) : (mst != 0);
        #1;
        if (hitcase != 0) begin
            chk(wr != 0 ? "R4 write hit done" : "R9 read hit done", cpu_done, 1);
            chk(wr != 0 ? "R4 no bus" : "R9 no bus", bus_req, 0);
            @(negedge clk);
            cpu_rd = 0; cpu_wr = 0;
            if (wr != 0) mst = 3;
            chk(wr != 0 ? "R4 state M" : "R9 state kept", line_state, mst);
        end else begin
            chk("R2 R5 not done at request", cpu_done, 0);
            @(negedge clk);
            chk("R2 R5 bus_req", bus_req, 1);
            chk(wr != 0 ? "R5 cmd rdx" : "R2 cmd rd", bus_cmd, wr);
            if (wr != 0) chk("R1 upgrade visible", line_state, (mst == 1) ? 1 : 0);
            for (int k = 0; k < gdly; k++) begin
                @(negedge clk);
                chk("R2 R5 req held", bus_req, 1);
                chk("R2 R5 no early done", cpu_done, 0);
            end
            bus_gnt = 1;
            #1;
            if (wr != 0) chk("R5 done at grant", cpu_done, 1);
            else         chk("R2 not done at grant", cpu_done, 0);
            @(negedge clk);
            bus_gnt = 0;
            if (wr != 0) begin
                cpu_wr = 0;
                mst = 3;
                chk("R5 state M", line_state, 3);
            end else begin
                chk("R1 fill pending shows I", line_state, 0);
                shr_in = shr[0];
                #1;
                chk("R2 done after grant", cpu_done, 1);
                chk("R2 req dropped", bus_req, 0);
                @(negedge clk);
                cpu_rd = 0; shr_in = 0;
                mst = (shr != 0) ? 1 : 2;
                chk("R2 fill state", line_state, mst);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset state", line_state, 0);
        chk("R1 reset req", bus_req, 0);
        chk("R1 reset shr", shr_out, 0);
        chk("R1 reset sup", sup_out, 0);
        chk("R1 reset done", cpu_done, 0);
        rst_n = 1;
        @(negedge clk);

        // R2: miss, nobody shares -> E; R4 silent write; R6 dirty flush
        do_cpu(0, 0, 2);
        do_cpu(1, 0, 0);
        do_snoop(1, 0, 1, 0, 0, 0);
        // R3 on S and R8 clean supplier with priority
        do_snoop(1, 0, 1, 1, 0, 0);
        // R5 upgrade S -> M, R7 flush on rdx from M
        do_cpu(1, 0, 1);
        do_snoop(1, 1, 1, 0, 0, 0);
        // R2 shared fill, R11 snoop without match / without valid
        do_cpu(0, 1, 0);
        do_snoop(1, 1, 0, 1, 0, 0);
        do_snoop(0, 1, 1, 1, 0, 0);
        // R7 rdx on S with priority
        do_snoop(1, 1, 1, 1, 0, 0);

        // R10: E with write colliding with rdx; write then misses
        do_cpu(0, 0, 0);
        do_snoop(1, 1, 1, 0, 0, 1);
        do_cpu(1, 0, 1);
        // R10: M read colliding with snooped read
        do_snoop(1, 0, 1, 0, 1, 0);
        do_cpu(0, 0, 0);

        // R7: rdx while upgrade pending from S
        cpu_wr = 1;
        #1 chk("R5 upgrade not done at request", cpu_done, 0);
        @(negedge clk);
        chk("R1 upgrade pending shows S", line_state, 1);
        snp_vld = 1; snp_match = 1; snp_cmd = 0;
        @(negedge clk);
        chk("R3 shr during upgrade", shr_out, 1);
        snp_cmd = 1;
        @(negedge clk);
        snp_vld = 0; snp_match = 0;
        chk("R7 copy dropped during upgrade", line_state, 0);
        chk("R7 req held", bus_req, 1);
        chk("R7 cmd rdx", bus_cmd, 1);
        bus_gnt = 1;
        #1 chk("R7 done at grant", cpu_done, 1);
        @(negedge clk);
        bus_gnt = 0; cpu_wr = 0; mst = 3;
        chk("R7 ends in M", line_state, 3);

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 3);
            if (op == 0) do_cpu(0, $urandom_range(0, 1), $urandom_range(0, 3));
            else if (op == 1) do_cpu(1, 0, $urandom_range(0, 3));
            else do_snoop(($urandom_range(0, 3) != 0) ? 1 : 0, op - 2,
                          ($urandom_range(0, 3) != 0) ? 1 : 0, $urandom_range(0, 1), 0, 0);
            chk("R8 variants agree on state", line_state1, line_state);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule